// File: doc/BRIEF.md
# Two-Stage Cascaded Interrupt Priority Controller

This block collects sixteen device interrupt request lines and presents a single interrupt to the processor. The lines are split over two eight-line stages. The upper stage (lines 8 to 15) does not reach the processor directly. Its combined request enters the lower stage through that stage's line 2, which therefore carries no device of its own. Each stage resolves its own lines by fixed index order, lowest index first. Because of the cascade, the overall order from highest to lowest priority is 0, 1, 8, 9, 10, 11, 12, 13, 14, 15, 3, 4, 5, 6, 7. A line's priority depends only on which input it is wired to.

When the processor acknowledges, the block captures the winning line and returns an 8-bit type code. The code is the stage's 5-bit base followed by the 3-bit line index within that stage. The block also returns the 20-bit table address of the service routine, which is four times the code. The winner is then marked in service. That mark holds back requests of equal or lower priority until an end-of-interrupt pulse clears it. When a line of the upper stage is in service, the lower stage's cascade slot is marked as well, and a single end-of-interrupt clears both marks.

Top module: `irq_casc_ctrl`

## Requirements
- R1: After reset, `intr` is low, `type_code` is 0 and `vec_addr` is 0, and no line is pending or in service.
- R2: A rising edge on an unmasked device line is latched at the next clock edge, and `intr` is high from then on. `intr` stays high after the line falls, until the request is acknowledged.
- R3: When several requests are pending, the one acknowledged follows the fixed order 0, 1, 8, 9, 10, 11, 12, 13, 14, 15, 3, 4, 5, 6, 7, from highest to lowest.
- R4: On `ack`, `type_code` becomes {`master_base`, line[2:0]} for lines 0 to 7 and {`slave_base`, line[2:0]} for lines 8 to 15. `vec_addr` equals 4 × `type_code`, zero-extended to 20 bits. Both outputs appear one clock after `ack` is sampled and hold until the next accepted `ack`.
- R5: An accepted `ack` marks the winning line in service and clears its request latch, so that line does not interrupt again without a new rising edge.
- R6: A line that is in service blocks every request of equal or lower priority, and any higher-priority request may still interrupt. While any upper-stage line is in service, all upper-stage lines are blocked.
- R7: `eoi` clears the highest-priority in-service mark. If that mark belongs to an upper-stage line, the same pulse also clears the cascade slot of the lower stage.
- R8: A masked line (`irq_mask` bit = 1) still latches its rising edge but does not raise `intr`. Clearing the mask bit makes that latched request compete again. Mask bit 2 holds back the whole upper stage.
- R9: Device input `irq_req[2]` has no effect, because that slot carries the upper stage.
- R10: An `ack` while no request is eligible changes neither `type_code` nor any in-service mark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | 16 | Device request lines; bit 2 is unused |
| irq_mask | input | 16 | Per-line mask, 1 = masked; bit 2 masks the upper stage |
| master_base | input | 5 | Code base for lines 0 to 7 |
| slave_base | input | 5 | Code base for lines 8 to 15 |
| ack | input | 1 | Processor acknowledge, one-cycle pulse |
| eoi | input | 1 | End-of-interrupt, one-cycle pulse |
| intr | output | 1 | Interrupt request to the processor |
| type_code | output | 8 | Type code captured at the last accepted acknowledge |
| vec_addr | output | 20 | Service-table address, 4 × type_code |

## Verification
The bench builds the block with its default parameters: eight lines per stage, a 5-bit base, a 20-bit address and the cascade on lower line 2. The two bases are set to different values (0x01 and 0x0E), so every returned code shows which stage it came from. With eight lines per stage, every position of the cascaded order can be reached. This covers the slot where the upper stage sits between lines 1 and 3, nesting of a lower-stage line over an upper-stage service, and the double clear on end-of-interrupt.

// File: rtl/irq_casc_pkg.sv
// Shared constants for the cascaded interrupt controller.
// Assumes two stages of equal width, the upper feeding one slot of the lower.
package irq_casc_pkg;
    localparam int STAGE_LINES = 8;   // request lines per stage
    localparam int BASE_BITS   = 5;   // programmable code base width
    localparam int TABLE_BITS  = 20;  // service-table address width
    localparam int CASCADE_POS = 2;   // lower-stage slot fed by the upper stage
endpackage

// File: rtl/irq_casc_stage.sv
// One controller stage: edge-latches device requests, applies the mask,
// blocks against its in-service flags and picks the lowest-index eligible line.
// Assumes: lowest index = highest priority; take/eoi_clr are one-cycle pulses.
// With HAS_CAS set, slot CAS_IDX ignores its device pin and follows cas_in.
module irq_casc_stage #(
    parameter int N       = 8,
    parameter bit HAS_CAS = 1'b0,
    parameter int CAS_IDX = 2,
    localparam int IW     = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req_in,
    input  logic          cas_in,
    input  logic [N-1:0]  mask,
    input  logic          take,
    input  logic          eoi_clr,
    output logic          win_valid,
    output logic [IW-1:0] win_idx,
    output logic [N-1:0]  isr,
    output logic          isr_any,
    output logic [IW-1:0] isr_top
);
    localparam logic [N-1:0] DEV_MASK = HAS_CAS ? ~(N'(1) << CAS_IDX) : {N{1'b1}};

    logic [N-1:0] req_q;
    logic [N-1:0] latch_q;
    logic [N-1:0] rise;
    logic [N-1:0] src;
    logic [N-1:0] blk;
    logic [N-1:0] elig;
    logic [N-1:0] take_clr;
    logic         granted;

    assign rise     = req_in & ~req_q & DEV_MASK;
    assign src      = latch_q | (HAS_CAS ? (N'(cas_in) << CAS_IDX) : '0);
    assign elig     = src & ~mask & ~blk;
    assign granted  = take && win_valid;
    assign take_clr = granted ? (N'(1) << win_idx) : '0;
    assign isr_any  = |isr;

    // A line is blocked when it or any higher-priority line is in service.
    for (genvar k = 0; k < N; k++) begin : g_blk
        assign blk[k] = |isr[k:0];
    end

    // Remember the previous pin level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req_in;
    end

    // Request latches: set on a rising edge, cleared for the acknowledged winner.
    always_ff @(posedge clk) begin
        if (!rst_n) latch_q <= '0;
        else        latch_q <= (latch_q & ~take_clr) | rise;
    end

    // Pick the lowest-index eligible line.
    always_comb begin
        win_valid = |elig;
        win_idx   = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (elig[k]) win_idx = IW'(k);
        end
    end

    // Locate the highest-priority in-service flag.
    always_comb begin
        isr_top = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (isr[k]) isr_top = IW'(k);
        end
    end

    // In-service flags: end-of-interrupt clears the top one, a grant sets the winner.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isr <= '0;
        end else begin
            isr <= (isr & ~((eoi_clr && isr_any) ? (N'(1) << isr_top) : '0)) | take_clr;
        end
    end

    // R5: a grant leaves the winner in service on the next cycle.
    a_r5_grant_sets_service: assert property (@(posedge clk) disable iff (!rst_n)
        granted |=> isr[$past(win_idx)]);

    // R7: end-of-interrupt without a grant drops exactly one flag.
    a_r7_eoi_drops_one: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_clr && isr_any && !granted) |=> ($countones(isr) == $countones($past(isr)) - 1));

    if (HAS_CAS) begin : g_cas_chk
        // R9: the cascade slot never latches a device edge.
        a_r9_cascade_slot_unlatched: assert property (@(posedge clk) disable iff (!rst_n)
            !latch_q[CAS_IDX]);
    end
endmodule

// File: rtl/irq_casc_vector.sv
// Captures the type code of an acknowledged winner and forms its table address.
// Assumes grant is already qualified by a valid winner.
module irq_casc_vector #(
    parameter int BASE_W = 5,
    parameter int IDX_W  = 3,
    parameter int ADDR_W = 20,
    localparam int CODE_W = BASE_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              grant,
    input  logic              use_upper,
    input  logic [BASE_W-1:0] lower_base,
    input  logic [BASE_W-1:0] upper_base,
    input  logic [IDX_W-1:0]  lower_idx,
    input  logic [IDX_W-1:0]  upper_idx,
    output logic [CODE_W-1:0] code,
    output logic [ADDR_W-1:0] addr
);
    // Register the code of the stage that won.
    always_ff @(posedge clk) begin
        if (!rst_n)     code <= '0;
        else if (grant) code <= use_upper ? {upper_base, upper_idx} : {lower_base, lower_idx};
    end

    assign addr = ADDR_W'({code, 2'b00});

    // R10: without a grant the code holds.
    a_r10_code_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !grant |=> $stable(code));
endmodule

// File: rtl/irq_casc_ctrl.sv
// Top of the cascaded interrupt controller: an upper stage (lines 8..15)
// feeds slot CAS_IDX of the lower stage (lines 0..7). The lower stage's
// winner drives intr; ack captures the code, eoi clears the top service flag.
// Assumes ack and eoi are single-cycle pulses synchronous to clk.
module irq_casc_ctrl
    import irq_casc_pkg::*;
#(
    parameter int STAGE_N = STAGE_LINES,
    parameter int BASE_W  = BASE_BITS,
    parameter int ADDR_W  = TABLE_BITS,
    parameter int CAS_IDX = CASCADE_POS,
    localparam int LINES  = 2 * STAGE_N,
    localparam int IW     = $clog2(STAGE_N),
    localparam int CODE_W = BASE_W + IW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINES-1:0]  irq_req,
    input  logic [LINES-1:0]  irq_mask,
    input  logic [BASE_W-1:0] master_base,
    input  logic [BASE_W-1:0] slave_base,
    input  logic              ack,
    input  logic              eoi,
    output logic              intr,
    output logic [CODE_W-1:0] type_code,
    output logic [ADDR_W-1:0] vec_addr
);
    logic               m_valid, s_valid;
    logic [IW-1:0]      m_idx, s_idx;
    logic [STAGE_N-1:0] m_isr, s_isr;
    logic               m_any, s_any;
    logic [IW-1:0]      m_top, s_top;
    logic               m_take, s_take, s_eoi, via_cas;

    assign via_cas = (m_idx == IW'(CAS_IDX));
    assign m_take  = ack && m_valid;
    assign s_take  = m_take && via_cas;
    assign s_eoi   = eoi && m_any && (m_top == IW'(CAS_IDX));
    assign intr    = m_valid;

    irq_casc_stage #(.N(STAGE_N), .HAS_CAS(1'b0), .CAS_IDX(CAS_IDX)) u_upper (
        .clk(clk), .rst_n(rst_n),
        .req_in(irq_req[LINES-1:STAGE_N]), .cas_in(1'b0),
        .mask(irq_mask[LINES-1:STAGE_N]),
        .take(s_take), .eoi_clr(s_eoi),
        .win_valid(s_valid), .win_idx(s_idx),
        .isr(s_isr), .isr_any(s_any), .isr_top(s_top)
    );

    irq_casc_stage #(.N(STAGE_N), .HAS_CAS(1'b1), .CAS_IDX(CAS_IDX)) u_lower (
        .clk(clk), .rst_n(rst_n),
        .req_in(irq_req[STAGE_N-1:0]), .cas_in(s_valid),
        .mask(irq_mask[STAGE_N-1:0]),
        .take(ack), .eoi_clr(eoi),
        .win_valid(m_valid), .win_idx(m_idx),
        .isr(m_isr), .isr_any(m_any), .isr_top(m_top)
    );

    irq_casc_vector #(.BASE_W(BASE_W), .IDX_W(IW), .ADDR_W(ADDR_W)) u_vec (
        .clk(clk), .rst_n(rst_n),
        .grant(m_take), .use_upper(via_cas),
        .lower_base(master_base), .upper_base(slave_base),
        .lower_idx(m_idx), .upper_idx(s_idx),
        .code(type_code), .addr(vec_addr)
    );

    // R7: the cascade slot is in service exactly when an upper line is.
    a_r7_cascade_pair: assert property (@(posedge clk) disable iff (!rst_n)
        m_isr[CAS_IDX] == s_any);

    // R6: at most one upper line is in service, and it is the one reported on top.
    a_r6_single_upper: assert property (@(posedge clk) disable iff (!rst_n)
        s_any |-> (s_isr == (STAGE_N'(1) << s_top)));

    // R2: intr is only offered while the processor side can be answered.
    a_r2_intr_has_winner: assert property (@(posedge clk) disable iff (!rst_n)
        (intr && via_cas) |-> s_valid);
endmodule

// File: tb/test_irq_casc_ctrl.sv
`timescale 1ns/1ps
module test_irq_casc_ctrl;
    localparam logic [4:0] MB = 5'h01;
    localparam logic [4:0] SB = 5'h0E;
    // Each entry: {request pattern, expected winning line}
    localparam int NV = 9;
    localparam logic [19:0] VEC [NV] = '{
        {16'h0003, 4'd0}, {16'h0006, 4'd1}, {16'h0108, 4'd8},
        {16'h8080, 4'd15}, {16'h00F8, 4'd3}, {16'hFF00, 4'd8},
        {16'h0C00, 4'd10}, {16'h0082, 4'd1}, {16'h4010, 4'd14}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_req = '0;
    logic [15:0] irq_mask = '0;
    logic        ack = 1'b0;
    logic        eoi = 1'b0;
    logic        intr;
    logic [7:0]  type_code;
    logic [19:0] vec_addr;
    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    irq_casc_ctrl i_irq_casc_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_mask(irq_mask),
        .master_base(MB), .slave_base(SB), .ack(ack), .eoi(eoi),
        .intr(intr), .type_code(type_code), .vec_addr(vec_addr)
    );

    function automatic logic [7:0] code_of(input int line);
        return (line < 8) ? {MB, 3'(line)} : {SB, 3'(line)};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; irq_req = '0; irq_mask = '0; ack = 1'b0; eoi = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse(input logic [15:0] pat);
        irq_req = pat;
        @(negedge clk);
        irq_req = '0;
        @(negedge clk);
    endtask

    task automatic do_ack();
        ack = 1'b1; @(negedge clk); ack = 1'b0;
    endtask

    task automatic do_eoi();
        eoi = 1'b1; @(negedge clk); eoi = 1'b0;
    endtask

    task automatic ack_expect(input string tag, input int line);
        do_ack();
        check(tag, type_code, code_of(line));
        check(tag, vec_addr, {10'd0, code_of(line), 2'b00});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        check("R1 intr", intr, 0);
        check("R1 code", type_code, 0);
        check("R1 addr", vec_addr, 0);

        // R3/R4 priority table walk
        for (int v = 0; v < NV; v++) begin
            do_reset();
            pulse(VEC[v][19:4]);
            check("R2 intr after edge", intr, 1);
            ack_expect("R3 R4 winner code", int'(VEC[v][3:0]));
        end

        // R9: device pin 2 alone does nothing
        do_reset();
        pulse(16'h0004);
        repeat (2) @(negedge clk);
        check("R9 pin2 ignored", intr, 0);

        // R2 + R5: intr holds until ack, then latch is gone
        do_reset();
        irq_req = 16'h0010;
        @(negedge clk);
        irq_req = '0;
        repeat (3) @(negedge clk);
        check("R2 intr held", intr, 1);
        ack_expect("R5 line4", 4);
        check("R5 blocked while in service", intr, 0);
        do_eoi();
        check("R5 latch cleared", intr, 0);

        // R8: masking, including the cascade slot
        do_reset();
        irq_mask = 16'h0020;
        pulse(16'h0020);
        check("R8 masked no intr", intr, 0);
        irq_mask = '0;
        @(negedge clk);
        check("R8 unmask raises", intr, 1);
        ack_expect("R8 line5", 5);
        do_eoi();
        irq_mask = 16'h0004;
        pulse(16'h0200);
        check("R8 upper stage masked", intr, 0);
        irq_mask = '0;
        @(negedge clk);
        check("R8 upper unmask", intr, 1);
        ack_expect("R8 line9", 9);
        do_eoi();

        // R6 + R7: nesting inside the lower stage
        do_reset();
        pulse(16'h0008);
        ack_expect("R6 line3", 3);
        pulse(16'h0020);
        check("R6 lower prio blocked", intr, 0);
        pulse(16'h0002);
        check("R6 higher nests", intr, 1);
        ack_expect("R6 line1", 1);
        do_eoi();
        check("R7 eoi cleared only line1", intr, 0);
        do_eoi();
        check("R7 eoi cleared line3", intr, 1);
        ack_expect("R7 line5", 5);
        do_eoi();

        // R6 + R7: upper-stage service and double clear
        do_reset();
        pulse(16'h0200);
        ack_expect("R6 line9", 9);
        pulse(16'h0100);
        check("R6 upper blocks upper", intr, 0);
        pulse(16'h0001);
        check("R6 line0 nests over upper", intr, 1);
        ack_expect("R6 line0", 0);
        do_eoi();
        check("R7 line0 cleared first", intr, 0);
        do_eoi();
        check("R7 upper and slot cleared", intr, 1);
        ack_expect("R7 line8", 8);
        do_eoi();
        pulse(16'h0008);
        check("R7 slot free for line3", intr, 1);

        // R10: ack with nothing eligible
        ack_expect("R10 line3", 3);
        do_ack();
        check("R10 code kept", type_code, code_of(3));
        do_eoi();
        pulse(16'h0040);
        check("R10 service state intact", intr, 1);
        ack_expect("R10 line6", 6);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule